// File: doc/BRIEF.md
# Eight-Bit ALU with Status Word

This block is the arithmetic and logic datapath of a small 8-bit processor core. The operand and opcode inputs produce a combinational result and a combinational next-status value in the same cycle. The block holds an 8-bit processor status word in a register. That word supplies the incoming carry and half-carry, and it takes the new flags on any clock edge where the operation is enabled.

The operation set covers the following:
- Binary add and subtract, both of which use the carry flag.
- Increment and decrement.
- The three bitwise logic operations.
- Two shifts and two rotates through carry.
- A nibble exchange.
- A compare that stores no result.
- Decimal correction after a BCD add or a BCD subtract.
- Clear, set and complement of the carry flag, and clear of the overflow flag.
- A status-load operation that writes the whole word from the memory operand.

The status-load operation is how the surrounding sequencer restores flags, for example after popping them from the stack.

The status word layout is fixed. From bit 7 down to bit 0 it holds:
- N, negative.
- V, overflow.
- P, direct-page select.
- B, break.
- H, half-carry.
- I, interrupt enable.
- Z, zero.
- C, carry.

The unary operations (increment, decrement, shifts, rotates, nibble exchange and decimal correction) act on the accumulator operand. When an operation produces no result, the result output repeats the accumulator operand.

Top module: `byte_alu_psw`

## Requirements
- R1: A synchronous active-low reset clears the status word to 0x00, whatever the opcode and enable inputs are.
- R2: The status word takes `flags_nxt` only on a rising edge with `op_en` high. With `op_en` low it holds its value, even though `flags_nxt` still shows the would-be update.
- R3: Opcode 0 (add with carry) gives result = A + M + C.
  - C is the carry out of bit 7.
  - H is the carry out of bit 3.
  - V is the signed overflow.
  - N and Z follow the result.
- R4: Opcode 1 (subtract with carry) gives result = A − M − (1 − C).
  - C = 1 means there was no borrow.
  - H = 1 means there was no borrow from bit 4 into bit 3.
  - V is the signed overflow.
  - N and Z follow the result.
- R5: Opcode 2 (A + 1) and opcode 3 (A − 1) update only N and Z.
- R6: Opcodes 4 (AND), 5 (OR) and 6 (XOR) combine A with M. They update only N and Z.
- R7: Opcode 7 shifts A left with a zero fill, and opcode 8 shifts A right with a zero fill into bit 7. In both cases the bit shifted out goes to C, and N and Z follow the result.
- R8: Opcode 9 rotates A left and opcode 10 rotates A right, both through carry. The old C enters the vacated bit, the bit shifted out becomes the new C, and N and Z follow the result.
- R9: Opcode 11 swaps bits 7:4 and bits 3:0 of A. N and Z follow the swapped value, and the other flags are unchanged.
- R10: Opcode 12 (compare) sets N and Z from A − M and sets C = 1 when there is no borrow. V and H are unchanged, and the result output equals A.
- R11: Opcode 13 (decimal correct after add) works in two steps.
  - If C = 1 or A > 0x99, it adds 0x60 and sets C.
  - If H = 1 or A[3:0] > 9, it adds 0x06.
  - N and Z follow the result. V and H are unchanged.
- R12: Opcode 14 (decimal correct after subtract) works in two steps.
  - If C = 0 or A > 0x99, it subtracts 0x60 and clears C.
  - If H = 0 or A[3:0] > 9, it subtracts 0x06.
  - N and Z follow the result. V and H are unchanged.
- R13: The flag-only opcodes change only their own bit: 15 clears C, 16 sets C, 17 inverts C and 18 clears V.
  - Opcode 19 loads the whole status word from M.
  - Opcodes 20 to 31 leave the status word unchanged.
  - For all of these opcodes the result equals A.
- R14: The P (bit 5), B (bit 4) and I (bit 2) flags change only through opcode 19 and through reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_en | input | 1 | Commit `flags_nxt` into the status word on this edge |
| op | input | 5 | Operation code |
| acc_in | input | 8 | Accumulator operand A |
| mem_in | input | 8 | Memory operand M |
| result | output | 8 | Combinational result |
| flags_nxt | output | 8 | Combinational next status word |
| psw_q | output | 8 | Registered status word |

## Verification
The hardest cases to reach are the ones that depend on flag states no ordinary arithmetic sequence sets up on purpose. Examples are decimal correction with H set but C clear, subtraction entered with a pending borrow, and arithmetic run while P, B and I are set. The bench reaches each of these directly. Before every table vector it issues the status-load opcode with a chosen word, so each operation starts from an exact flag state. It then checks both the combinational result and the registered word one edge later.

// File: rtl/alu_pkg.sv
// Shared definitions for the 8-bit ALU: widths, status bit positions,
// operation codes and shift kinds. Assumes a fixed 8-bit status word.
package alu_pkg;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned PSW_W  = 8;
    localparam int unsigned OP_W   = 5;

    localparam int unsigned FLAG_C = 0;
    localparam int unsigned FLAG_Z = 1;
    localparam int unsigned FLAG_I = 2;
    localparam int unsigned FLAG_H = 3;
    localparam int unsigned FLAG_B = 4;
    localparam int unsigned FLAG_P = 5;
    localparam int unsigned FLAG_V = 6;
    localparam int unsigned FLAG_N = 7;

    typedef enum logic [OP_W-1:0] {
        OP_ADC   = 5'd0,
        OP_SBC   = 5'd1,
        OP_INC   = 5'd2,
        OP_DEC   = 5'd3,
        OP_AND   = 5'd4,
        OP_OR    = 5'd5,
        OP_EOR   = 5'd6,
        OP_ASL   = 5'd7,
        OP_LSR   = 5'd8,
        OP_ROL   = 5'd9,
        OP_ROR   = 5'd10,
        OP_XCN   = 5'd11,
        OP_CMP   = 5'd12,
        OP_DAA   = 5'd13,
        OP_DAS   = 5'd14,
        OP_CLRC  = 5'd15,
        OP_SETC  = 5'd16,
        OP_NOTC  = 5'd17,
        OP_CLRV  = 5'd18,
        OP_LDPSW = 5'd19
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_ASL = 2'd0,
        SH_LSR = 2'd1,
        SH_ROL = 2'd2,
        SH_ROR = 2'd3
    } shift_kind_e;
endpackage

// File: rtl/alu_addsub.sv
// Adder split at the half-word boundary so the carry out of the low half
// is visible as the half-carry. Subtraction is done by inverting b; the
// caller supplies the carry-in (1 for a plain subtract, C for borrow-in).
// Assumes W is even.
module alu_addsub #(
    parameter int unsigned W = alu_pkg::DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         half,
    output logic         ovf
);
    localparam int unsigned LO_W = W / 2;
    localparam int unsigned HI_W = W - LO_W;

    logic [W-1:0]  b_eff;
    logic [LO_W:0] lo_sum;
    logic [HI_W:0] hi_sum;

    // Low half then high half, chained through the half carry.
    always_comb begin
        b_eff  = sub ? ~b : b;
        lo_sum = {1'b0, a[LO_W-1:0]} + {1'b0, b_eff[LO_W-1:0]} + {{LO_W{1'b0}}, cin};
        hi_sum = {1'b0, a[W-1:LO_W]} + {1'b0, b_eff[W-1:LO_W]} + {{HI_W{1'b0}}, lo_sum[LO_W]};
    end

    assign sum  = {hi_sum[HI_W-1:0], lo_sum[LO_W-1:0]};
    assign cout = hi_sum[HI_W];
    assign half = lo_sum[LO_W];
    assign ovf  = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
endmodule

// File: rtl/alu_shift.sv
// One-position shifter: shift left or right with zero fill, or rotate
// through the incoming carry. The bit pushed out is returned as cout.
module alu_shift #(
    parameter int unsigned W = alu_pkg::DATA_W
) (
    input  logic [W-1:0]        a,
    input  alu_pkg::shift_kind_e kind,
    input  logic                cin,
    output logic [W-1:0]        y,
    output logic                cout
);
    // Select the fill bit and direction for the requested kind.
    always_comb begin
        unique case (kind)
            alu_pkg::SH_ASL: begin y = {a[W-2:0], 1'b0}; cout = a[W-1]; end
            alu_pkg::SH_LSR: begin y = {1'b0, a[W-1:1]}; cout = a[0];   end
            alu_pkg::SH_ROL: begin y = {a[W-2:0], cin};  cout = a[W-1]; end
            default:         begin y = {cin, a[W-1:1]};  cout = a[0];   end
        endcase
    end
endmodule

// File: rtl/alu_decadj.sv
// Decimal correction of a packed-BCD byte after a binary add (sub=0) or
// subtract (sub=1), steered by the carry and half-carry of that operation.
// Assumes W is a multiple of 4; the upper step acts on the top digit.
module alu_decadj #(
    parameter int unsigned W = alu_pkg::DATA_W
) (
    input  logic [W-1:0] a,
    input  logic         c_in,
    input  logic         h_in,
    input  logic         sub,
    output logic [W-1:0] y,
    output logic         c_out
);
    localparam logic [W-1:0] DEC_LIMIT = {(W/4){4'h9}};
    localparam logic [W-1:0] LO_STEP   = W'(6);
    localparam logic [W-1:0] HI_STEP   = LO_STEP << (W - 4);

    logic hi_fix;
    logic lo_fix;
    logic [W-1:0] step;

    // Decide which digits need correcting and apply both steps at once.
    always_comb begin
        if (sub) begin
            hi_fix = !c_in || (a > DEC_LIMIT);
            lo_fix = !h_in || (a[3:0] > 4'd9);
        end else begin
            hi_fix = c_in || (a > DEC_LIMIT);
            lo_fix = h_in || (a[3:0] > 4'd9);
        end
        step  = (hi_fix ? HI_STEP : '0) + (lo_fix ? LO_STEP : '0);
        y     = sub ? (a - step) : (a + step);
        c_out = sub ? (c_in && !hi_fix) : (c_in || hi_fix);
    end
endmodule

// File: rtl/byte_alu_psw.sv
// Top of the 8-bit ALU. Decodes the opcode, selects among the adder,
// shifter, decimal corrector and inline logic, forms the next status word
// and registers it when op_en is high. Assumes DW equals the status width.
module byte_alu_psw #(
    parameter int unsigned DW = alu_pkg::DATA_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     op_en,
    input  logic [alu_pkg::OP_W-1:0] op,
    input  logic [DW-1:0]            acc_in,
    input  logic [DW-1:0]            mem_in,
    output logic [DW-1:0]            result,
    output logic [7:0]               flags_nxt,
    output logic [7:0]               psw_q
);
    import alu_pkg::*;

    localparam int unsigned HALF = DW / 2;

    logic [DW-1:0] as_sum;
    logic          as_cout, as_half, as_ovf, as_sub, as_cin;
    logic [DW-1:0] sh_y;
    logic          sh_cout;
    shift_kind_e   sh_kind;
    logic [DW-1:0] da_y;
    logic          da_cout;
    logic [DW-1:0] nz_val;
    logic          nz_upd;

    // Adder controls: add only for opcode 0; compare forces carry-in high.
    always_comb begin
        as_sub = (op != OP_ADC);
        as_cin = (op == OP_CMP) ? 1'b1 : psw_q[FLAG_C];
    end

    // Map the shift/rotate opcodes to the shifter kind.
    always_comb begin
        case (op)
            OP_LSR:  sh_kind = SH_LSR;
            OP_ROL:  sh_kind = SH_ROL;
            OP_ROR:  sh_kind = SH_ROR;
            default: sh_kind = SH_ASL;
        endcase
    end

    alu_addsub #(.W(DW)) u_addsub (
        .a(acc_in), .b(mem_in), .sub(as_sub), .cin(as_cin),
        .sum(as_sum), .cout(as_cout), .half(as_half), .ovf(as_ovf)
    );

    alu_shift #(.W(DW)) u_shift (
        .a(acc_in), .kind(sh_kind), .cin(psw_q[FLAG_C]),
        .y(sh_y), .cout(sh_cout)
    );

    alu_decadj #(.W(DW)) u_decadj (
        .a(acc_in), .c_in(psw_q[FLAG_C]), .h_in(psw_q[FLAG_H]),
        .sub(op == OP_DAS), .y(da_y), .c_out(da_cout)
    );

    // Result and next-flag selection per opcode; N/Z from nz_val when set.
    always_comb begin
        result    = acc_in;
        flags_nxt = psw_q;
        nz_val    = acc_in;
        nz_upd    = 1'b1;
        case (op)
            OP_ADC, OP_SBC: begin
                result            = as_sum;
                nz_val            = as_sum;
                flags_nxt[FLAG_C] = as_cout;
                flags_nxt[FLAG_H] = as_half;
                flags_nxt[FLAG_V] = as_ovf;
            end
            OP_INC: begin
                result = acc_in + DW'(1);
                nz_val = acc_in + DW'(1);
            end
            OP_DEC: begin
                result = acc_in - DW'(1);
                nz_val = acc_in - DW'(1);
            end
            OP_AND: begin result = acc_in & mem_in; nz_val = acc_in & mem_in; end
            OP_OR:  begin result = acc_in | mem_in; nz_val = acc_in | mem_in; end
            OP_EOR: begin result = acc_in ^ mem_in; nz_val = acc_in ^ mem_in; end
            OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
                result            = sh_y;
                nz_val            = sh_y;
                flags_nxt[FLAG_C] = sh_cout;
            end
            OP_XCN: begin
                result = {acc_in[HALF-1:0], acc_in[DW-1:HALF]};
                nz_val = {acc_in[HALF-1:0], acc_in[DW-1:HALF]};
            end
            OP_CMP: begin
                nz_val            = as_sum;
                flags_nxt[FLAG_C] = as_cout;
            end
            OP_DAA, OP_DAS: begin
                result            = da_y;
                nz_val            = da_y;
                flags_nxt[FLAG_C] = da_cout;
            end
            OP_CLRC: begin nz_upd = 1'b0; flags_nxt[FLAG_C] = 1'b0; end
            OP_SETC: begin nz_upd = 1'b0; flags_nxt[FLAG_C] = 1'b1; end
            OP_NOTC: begin nz_upd = 1'b0; flags_nxt[FLAG_C] = ~psw_q[FLAG_C]; end
            OP_CLRV: begin nz_upd = 1'b0; flags_nxt[FLAG_V] = 1'b0; end
            OP_LDPSW: begin nz_upd = 1'b0; flags_nxt = mem_in[7:0]; end
            default: nz_upd = 1'b0;
        endcase
        if (nz_upd) begin
            flags_nxt[FLAG_N] = nz_val[DW-1];
            flags_nxt[FLAG_Z] = (nz_val == '0);
        end
    end

    // Status word register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     psw_q <= '0;
        else if (op_en) psw_q <= flags_nxt;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (psw_q == 8'h00));
    // R2
    psw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_en |=> $stable(psw_q));
    // R14
    ctrl_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && op != OP_LDPSW) |=>
        (psw_q[FLAG_P] == $past(psw_q[FLAG_P]) && psw_q[FLAG_B] == $past(psw_q[FLAG_B])
         && psw_q[FLAG_I] == $past(psw_q[FLAG_I])));
    // R10
    cmp_vh_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && op == OP_CMP) |=>
        (psw_q[FLAG_V] == $past(psw_q[FLAG_V]) && psw_q[FLAG_H] == $past(psw_q[FLAG_H])));
    // R5
    incdec_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && (op == OP_INC || op == OP_DEC)) |=>
        (psw_q[FLAG_C] == $past(psw_q[FLAG_C]) && psw_q[FLAG_V] == $past(psw_q[FLAG_V])
         && psw_q[FLAG_H] == $past(psw_q[FLAG_H])));
    // R6
    logic_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && (op == OP_AND || op == OP_OR || op == OP_EOR)) |=>
        (psw_q[FLAG_C] == $past(psw_q[FLAG_C]) && psw_q[FLAG_V] == $past(psw_q[FLAG_V])));
    // R13
    setc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && op == OP_SETC) |=> psw_q[FLAG_C]);
    // R13
    clrv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && op == OP_CLRV) |=> !psw_q[FLAG_V]);
endmodule

// File: tb/tb_byte_alu_psw.sv
module tb_byte_alu_psw;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_en = 1'b0;
    logic [4:0] op = 5'd0;
    logic [7:0] acc_in = 8'h00;
    logic [7:0] mem_in = 8'h00;
    logic [7:0] result, flags_nxt, psw_q;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    byte_alu_psw dut (
        .clk(clk), .rst_n(rst_n), .op_en(op_en), .op(op),
        .acc_in(acc_in), .mem_in(mem_in),
        .result(result), .flags_nxt(flags_nxt), .psw_q(psw_q)
    );

    typedef struct packed {
        logic [3:0] req;
        logic [4:0] op;
        logic [7:0] a;
        logic [7:0] m;
        logic [7:0] pin;
        logic [7:0] res;
        logic [7:0] pout;
    } vec_t;

    localparam int NV = 32;
    // Fields: req, op, A, M, status before, expected result, expected status.
    localparam vec_t VECS [NV] = '{
        '{4'd3,  5'd0,  8'h3A, 8'h48, 8'h00, 8'h82, 8'hC8},  // R3 half carry, overflow
        '{4'd3,  5'd0,  8'hFF, 8'h00, 8'h25, 8'h00, 8'h2F},  // R3 carry in wraps to zero (R14 P,I kept)
        '{4'd4,  5'd1,  8'h50, 8'h10, 8'h01, 8'h40, 8'h09},  // R4 no borrow
        '{4'd4,  5'd1,  8'h00, 8'h01, 8'h00, 8'hFE, 8'h80},  // R4 borrow in and out
        '{4'd4,  5'd1,  8'h80, 8'h01, 8'h01, 8'h7F, 8'h41},  // R4 signed overflow
        '{4'd5,  5'd2,  8'hFF, 8'h00, 8'hC9, 8'h00, 8'h4B},  // R5 increment wraps
        '{4'd5,  5'd3,  8'h00, 8'h00, 8'h00, 8'hFF, 8'h80},  // R5 decrement wraps
        '{4'd6,  5'd4,  8'hF0, 8'h0F, 8'h41, 8'h00, 8'h43},  // R6 and
        '{4'd6,  5'd5,  8'h80, 8'h01, 8'h00, 8'h81, 8'h80},  // R6 or
        '{4'd6,  5'd6,  8'hAA, 8'hAA, 8'h83, 8'h00, 8'h03},  // R6 xor
        '{4'd7,  5'd7,  8'h81, 8'h00, 8'h00, 8'h02, 8'h01},  // R7 shift left
        '{4'd7,  5'd8,  8'h81, 8'h00, 8'h80, 8'h40, 8'h01},  // R7 shift right
        '{4'd7,  5'd8,  8'h01, 8'h00, 8'h00, 8'h00, 8'h03},  // R7 shift right to zero
        '{4'd8,  5'd9,  8'h80, 8'h00, 8'h01, 8'h01, 8'h01},  // R8 rotate left
        '{4'd8,  5'd10, 8'h01, 8'h00, 8'h01, 8'h80, 8'h81},  // R8 rotate right, carry in
        '{4'd8,  5'd10, 8'h02, 8'h00, 8'h00, 8'h01, 8'h00},  // R8 rotate right, carry clear
        '{4'd9,  5'd11, 8'h3C, 8'h00, 8'h01, 8'hC3, 8'h81},  // R9 nibble swap
        '{4'd9,  5'd11, 8'h00, 8'h00, 8'h00, 8'h00, 8'h02},  // R9 zero swap
        '{4'd10, 5'd12, 8'h10, 8'h20, 8'h48, 8'h10, 8'hC8},  // R10 compare borrow
        '{4'd10, 5'd12, 8'h20, 8'h20, 8'h00, 8'h20, 8'h03},  // R10 compare equal
        '{4'd11, 5'd13, 8'h9A, 8'h00, 8'h00, 8'h00, 8'h03},  // R11 both digits
        '{4'd11, 5'd13, 8'h15, 8'h00, 8'h08, 8'h1B, 8'h08},  // R11 half carry only
        '{4'd11, 5'd13, 8'h12, 8'h00, 8'h01, 8'h72, 8'h01},  // R11 carry only
        '{4'd12, 5'd14, 8'h4B, 8'h00, 8'h09, 8'h45, 8'h09},  // R12 low digit only
        '{4'd12, 5'd14, 8'h34, 8'h00, 8'h00, 8'hCE, 8'h80},  // R12 both digits
        '{4'd12, 5'd14, 8'h66, 8'h00, 8'h09, 8'h66, 8'h09},  // R12 no correction
        '{4'd13, 5'd15, 8'h55, 8'h00, 8'hFF, 8'h55, 8'hFE},  // R13 clear carry
        '{4'd13, 5'd16, 8'h55, 8'h00, 8'h00, 8'h55, 8'h01},  // R13 set carry
        '{4'd13, 5'd17, 8'h55, 8'h00, 8'h35, 8'h55, 8'h34},  // R13 invert carry
        '{4'd13, 5'd18, 8'h55, 8'h00, 8'hFF, 8'h55, 8'hBF},  // R13 clear overflow
        '{4'd13, 5'd20, 8'h12, 8'h00, 8'h5A, 8'h12, 8'h5A},  // R13 unused code
        '{4'd13, 5'd19, 8'h77, 8'hA5, 8'h00, 8'h77, 8'hA5}   // R13 status load
    };

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [4:0] o, input logic [7:0] a, input logic [7:0] m);
        @(negedge clk);
        op = o; acc_in = a; mem_in = m; op_en = 1'b1;
        @(posedge clk);
        #1 op_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset with a pending load still clears
        op = 5'd19; mem_in = 8'hFF; op_en = 1'b1;
        repeat (3) @(posedge clk);
        #1 chk("R1", "reset value", psw_q, 8'h00);
        @(negedge clk) rst_n = 1'b1; op_en = 1'b0;

        // Table walk: load the starting status, then apply the vector.
        for (int i = 0; i < NV; i++) begin
            issue(5'd19, 8'h00, VECS[i].pin);
            @(negedge clk);
            op = VECS[i].op; acc_in = VECS[i].a; mem_in = VECS[i].m; op_en = 1'b1;
            #1;
            chk($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d result", i), result, VECS[i].res);
            @(posedge clk);
            #1 op_en = 1'b0;
            chk($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d status", i), psw_q, VECS[i].pout);
        end

        // R2: update visible on flags_nxt but not committed while disabled
        issue(5'd19, 8'h00, 8'h00);
        @(negedge clk);
        op = 5'd16; acc_in = 8'h00; op_en = 1'b0;
        #1 chk("R2", "next flags while idle", flags_nxt, 8'h01);
        @(posedge clk);
        #1 chk("R2", "status held", psw_q, 8'h00);

        // R14: control bits survive arithmetic and carry ops
        issue(5'd19, 8'h00, 8'h34);
        issue(5'd1, 8'h00, 8'hFF);
        issue(5'd17, 8'h00, 8'h00);
        #1 chk("R14", "P B I kept", psw_q & 8'h34, 8'h34);

        // R1: reset in mid-run clears a loaded word
        issue(5'd19, 8'h00, 8'hFF);
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk);
        #1 chk("R1", "reset mid-run", psw_q, 8'h00);
        rst_n = 1'b1;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule